// File: doc/BRIEF.md
# CAN Node Fault Confinement Unit

This block keeps the two error tallies of a single CAN node, one for receive faults and one for transmit faults, and turns them into the node's fault standing. The standing is error-active, error-passive or bus-off. A separate warning flag rises early, before the node leaves the error-active state. Error detection and the protocol engine sit elsewhere. They report single-cycle event pulses for receive errors, transmit errors, good receptions and good transmissions.

While the node is bus-off, the unit watches the sampled bus level on each bit strobe. It counts runs of eleven consecutive recessive bits. Once 128 such runs have completed, the node returns by itself to error-active with both tallies cleared. A dominant sample only restarts the run in progress; runs already completed are kept.

The outputs tell the protocol engine two things: whether the node may take part on the bus at all, and whether its error flags are to be driven dominant or left recessive.

Top module: `can_fault_confine`

## Requirements
- R1: A transmit error pulse adds 8 to the 9-bit transmit tally. A good-transmit pulse subtracts 1 but never goes below 0. When both pulse in the same cycle, only the error is applied. The result is visible on the outputs after the next rising clock edge.
- R2: A receive error pulse adds 1 to the 8-bit receive tally and saturates at 255. A good-receive pulse subtracts 1 but never goes below 0. When both pulse in the same cycle, only the error is applied.
- R3: The state code is 2'b00 (error-active) while both tallies are below 128. It is 2'b01 (error-passive) while either tally is 128 or more and the transmit tally is below 256. It is 2'b10 (bus-off) while the transmit tally is 256 or more. The code 2'b11 never appears.
- R4: The warning output is high while either tally is 96 or more, and low while both are below 96.
- R5: The flag-polarity output is high (error flags dominant) only in error-active. The online output is low only in bus-off.
- R6: In bus-off, all four event pulses are ignored and both tallies hold their values.
- R7: In bus-off, after 128 completed runs of 11 recessive samples (bus bit 1, taken on bit strobes), the node returns to error-active with both tallies at 0. This takes effect on the clock edge that takes the final sample.
- R8: In bus-off, a dominant sample (bus bit 0) on a strobe restarts the current run of 11. Completed runs are kept.
- R9: After reset, both tallies are 0, the state is error-active, the warning is low, the flag polarity is dominant and the node is online.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err_i | input | 1 | Transmit error event pulse |
| tx_ok_i | input | 1 | Successful transmit event pulse |
| rx_err_i | input | 1 | Receive error event pulse |
| rx_ok_i | input | 1 | Successful receive event pulse |
| bit_strobe_i | input | 1 | One pulse per bus bit time, qualifies bus_bit_i |
| bus_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| tec_o | output | 9 | Transmit error tally |
| rec_o | output | 8 | Receive error tally |
| state_o | output | 2 | Fault state code |
| warn_o | output | 1 | Error warning flag |
| flag_dominant_o | output | 1 | Error flags to be sent dominant |
| online_o | output | 1 | Node may transmit and receive |

## Verification
The two tallies update independently, so a transmit error that pushes the node into bus-off can arrive in the same cycle as a good reception that lowers the receive tally. The bench drives both pulses together from a transmit tally of 254. After the next edge it expects a transmit tally of 262, a receive tally one lower than before, state bus-off and the online output low. The stimulus table also pairs each error with its own success pulse, to confirm that the error wins, and pairs a transmit event with a receive event, to confirm they do not disturb each other.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } fc_state_e;

endpackage

// File: rtl/can_fc_rst_sync.sv
module can_fc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/can_fc_err_cnt.sv
module can_fc_err_cnt #(
  parameter int W   = 8,
  parameter int INC = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_i,
  input  logic         clear_i,
  input  logic         err_i,
  input  logic         ok_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W:0]   INC_X = (W+1)'(INC);
  localparam logic [W-1:0] ZERO  = '0;
  localparam logic [W-1:0] ONE   = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;
  logic [W:0]   sum;

  assign sum = {1'b0, cnt_q} + INC_X;

  always_comb begin
    cnt_en = clear_i | (~hold_i & (err_i | ok_i));
    cnt_d  = cnt_q;
    if (clear_i) begin
      cnt_d = ZERO;
    end else if (err_i) begin
      cnt_d = sum[W] ? {W{1'b1}} : sum[W-1:0];
    end else if (ok_i && (cnt_q != ZERO)) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/can_fc_recovery.sv
module can_fc_recovery #(
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic strobe_i,
  input  logic bus_bit_i,
  output logic done_o
);

  localparam int BIT_W = $clog2(RUN_LEN + 1);
  localparam int RUN_W = $clog2(RUN_COUNT + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(RUN_LEN - 1);
  localparam logic [RUN_W-1:0] LAST_RUN = RUN_W'(RUN_COUNT - 1);

  logic [BIT_W-1:0] bit_q, bit_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             run_end;
  logic             rec_en;

  assign run_end = strobe_i & bus_bit_i & (bit_q == LAST_BIT);
  assign done_o  = active_i & run_end & (run_q == LAST_RUN);

  always_comb begin
    rec_en = ~active_i | strobe_i;
    bit_d  = bit_q;
    run_d  = run_q;
    if (!active_i) begin
      bit_d = '0;
      run_d = '0;
    end else if (strobe_i) begin
      if (!bus_bit_i) begin
        bit_d = '0;
      end else if (run_end) begin
        bit_d = '0;
        run_d = done_o ? '0 : run_q + RUN_W'(1);
      end else begin
        bit_d = bit_q + BIT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      run_q <= '0;
    end else if (rec_en) begin
      bit_q <= bit_d;
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/can_fc_state_dec.sv
module can_fc_state_dec
  import can_fc_pkg::*;
#(
  parameter int TEC_W       = 9,
  parameter int REC_W       = 8,
  parameter int WARN_LIM    = 96,
  parameter int PASSIVE_LIM = 128,
  parameter int BUSOFF_LIM  = 256
) (
  input  logic [TEC_W-1:0] tec_i,
  input  logic [REC_W-1:0] rec_i,
  output logic [1:0]       state_o,
  output logic             warn_o,
  output logic             flag_dominant_o,
  output logic             online_o
);

  localparam logic [TEC_W-1:0] TEC_WARN = TEC_W'(WARN_LIM);
  localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASSIVE_LIM);
  localparam logic [TEC_W-1:0] TEC_OFF  = TEC_W'(BUSOFF_LIM);
  localparam logic [REC_W-1:0] REC_WARN = REC_W'(WARN_LIM);
  localparam logic [REC_W-1:0] REC_PASS = REC_W'(PASSIVE_LIM);

  fc_state_e st;

  always_comb begin
    if (tec_i >= TEC_OFF) begin
      st = FC_BUSOFF;
    end else if ((tec_i >= TEC_PASS) || (rec_i >= REC_PASS)) begin
      st = FC_PASSIVE;
    end else begin
      st = FC_ACTIVE;
    end
  end

  assign state_o         = st;
  assign warn_o          = (tec_i >= TEC_WARN) || (rec_i >= REC_WARN);
  assign flag_dominant_o = (st == FC_ACTIVE);
  assign online_o        = (st != FC_BUSOFF);

endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
  import can_fc_pkg::*;
#(
  parameter int REC_W       = 8,
  parameter int TX_ERR_INC  = 8,
  parameter int RX_ERR_INC  = 1,
  parameter int WARN_LIM    = 96,
  parameter int PASSIVE_LIM = 128,
  parameter int BUSOFF_LIM  = 256,
  parameter int RUN_LEN     = 11,
  parameter int RUN_COUNT   = 128,
  localparam int TEC_W      = $clog2(BUSOFF_LIM + TX_ERR_INC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_err_i,
  input  logic             rx_ok_i,
  input  logic             bit_strobe_i,
  input  logic             bus_bit_i,
  output logic [TEC_W-1:0] tec_o,
  output logic [REC_W-1:0] rec_o,
  output logic [1:0]       state_o,
  output logic             warn_o,
  output logic             flag_dominant_o,
  output logic             online_o
);

  logic rst_int_n;
  logic bus_off;
  logic recover;

  can_fc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign bus_off = (state_o == FC_BUSOFF);

  can_fc_err_cnt #(.W(TEC_W), .INC(TX_ERR_INC)) u_tec (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .hold_i  (bus_off),
    .clear_i (recover),
    .err_i   (tx_err_i),
    .ok_i    (tx_ok_i),
    .cnt_o   (tec_o)
  );

  can_fc_err_cnt #(.W(REC_W), .INC(RX_ERR_INC)) u_rec (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .hold_i  (bus_off),
    .clear_i (recover),
    .err_i   (rx_err_i),
    .ok_i    (rx_ok_i),
    .cnt_o   (rec_o)
  );

  can_fc_recovery #(.RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)) u_recov (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .active_i  (bus_off),
    .strobe_i  (bit_strobe_i),
    .bus_bit_i (bus_bit_i),
    .done_o    (recover)
  );

  can_fc_state_dec #(
    .TEC_W       (TEC_W),
    .REC_W       (REC_W),
    .WARN_LIM    (WARN_LIM),
    .PASSIVE_LIM (PASSIVE_LIM),
    .BUSOFF_LIM  (BUSOFF_LIM)
  ) u_dec (
    .tec_i           (tec_o),
    .rec_i           (rec_o),
    .state_o         (state_o),
    .warn_o          (warn_o),
    .flag_dominant_o (flag_dominant_o),
    .online_o        (online_o)
  );

endmodule

// File: rtl/can_fault_confine_chk.sv
module can_fault_confine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_err_i,
  input logic       rx_err_i,
  input logic [8:0] tec_o,
  input logic [7:0] rec_o,
  input logic [1:0] state_o,
  input logic       flag_dominant_o,
  input logic       online_o
);

  // R1
  tx_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'b10 && tx_err_i) |=> (tec_o == $past(tec_o) + 9'd8));

  // R2
  rx_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'b10 && rx_err_i && rec_o != 8'hFF) |=> (rec_o == $past(rec_o) + 8'd1));

  // R3
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'b11);

  // R5
  flag_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_dominant_o == (state_o == 2'b00)) && (online_o == (state_o != 2'b10)));

  // R6
  busoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b10) |=> ($stable(tec_o) && $stable(rec_o)) || (tec_o == 9'd0 && rec_o == 8'd0));

  // R7
  exit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b10) |=> (state_o == 2'b10) || (state_o == 2'b00 && tec_o == 9'd0 && rec_o == 8'd0));

endmodule

bind can_fault_confine can_fault_confine_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .tx_err_i        (tx_err_i),
  .rx_err_i        (rx_err_i),
  .tec_o           (tec_o),
  .rec_o           (rec_o),
  .state_o         (state_o),
  .flag_dominant_o (flag_dominant_o),
  .online_o        (online_o)
);

// File: tb/can_fault_confine_tb.sv
module can_fault_confine_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_err = 1'b0, tx_ok = 1'b0, rx_err = 1'b0, rx_ok = 1'b0;
  logic       strobe = 1'b0, bus_bit = 1'b1;
  logic [8:0] tec;
  logic [7:0] rec;
  logic [1:0] state;
  logic       warn, flag_dom, online;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  can_fault_confine u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .tx_err_i        (tx_err),
    .tx_ok_i         (tx_ok),
    .rx_err_i        (rx_err),
    .rx_ok_i         (rx_ok),
    .bit_strobe_i    (strobe),
    .bus_bit_i       (bus_bit),
    .tec_o           (tec),
    .rec_o           (rec),
    .state_o         (state),
    .warn_o          (warn),
    .flag_dominant_o (flag_dom),
    .online_o        (online)
  );

  // {tx_err,tx_ok,rx_err,rx_ok, tec(9), rec(8), state(2), warn}
  localparam logic [23:0] VEC [10] = '{
    {4'b1000, 9'd8,  8'd0, 2'd0, 1'b0},
    {4'b1000, 9'd16, 8'd0, 2'd0, 1'b0},
    {4'b0100, 9'd15, 8'd0, 2'd0, 1'b0},
    {4'b0010, 9'd15, 8'd1, 2'd0, 1'b0},
    {4'b0001, 9'd15, 8'd0, 2'd0, 1'b0},
    {4'b0001, 9'd15, 8'd0, 2'd0, 1'b0},
    {4'b1100, 9'd23, 8'd0, 2'd0, 1'b0},
    {4'b0011, 9'd23, 8'd1, 2'd0, 1'b0},
    {4'b0101, 9'd22, 8'd0, 2'd0, 1'b0},
    {4'b1010, 9'd30, 8'd1, 2'd0, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic te, input logic to, input logic re, input logic ro);
    @(negedge clk);
    tx_err = te; tx_ok = to; rx_err = re; rx_ok = ro;
    @(negedge clk);
    tx_err = 1'b0; tx_ok = 1'b0; rx_err = 1'b0; rx_ok = 1'b0;
  endtask

  task automatic sample(input logic b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      strobe = 1'b1; bus_bit = b;
      @(negedge clk);
      strobe = 1'b0; bus_bit = 1'b1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 tec", int'(tec), 0);
    check("R9 rec", int'(rec), 0);
    check("R9 state", int'(state), 0);
    check("R9 warn", int'(warn), 0);
    check("R9 flag", int'(flag_dom), 1);
    check("R9 online", int'(online), 1);

    // R1 R2 table of event patterns
    foreach (VEC[k]) begin
      pulse(VEC[k][23], VEC[k][22], VEC[k][21], VEC[k][20]);
      check("R1 tec table", int'(tec), int'(VEC[k][19:11]));
      check("R2 rec table", int'(rec), int'(VEC[k][10:3]));
      check("R3 state table", int'(state), int'(VEC[k][2:1]));
      check("R4 warn table", int'(warn), int'(VEC[k][0]));
    end

    // R4 warning threshold
    for (int i = 0; i < 8; i++) pulse(1, 0, 0, 0);
    check("R4 tec 94", int'(tec), 94);
    check("R4 warn below", int'(warn), 0);
    pulse(1, 0, 0, 0);
    check("R4 warn at 102", int'(warn), 1);
    check("R3 still active", int'(state), 0);

    // R3 R5 passive threshold
    for (int i = 0; i < 3; i++) pulse(1, 0, 0, 0);
    check("R3 active at 126", int'(state), 0);
    check("R5 flag active", int'(flag_dom), 1);
    pulse(1, 0, 0, 0);
    check("R3 tec 134", int'(tec), 134);
    check("R3 passive", int'(state), 1);
    check("R5 flag passive", int'(flag_dom), 0);
    check("R5 online passive", int'(online), 1);

    // R2 saturation
    for (int i = 0; i < 260; i++) pulse(0, 0, 1, 0);
    check("R2 rec saturates", int'(rec), 255);

    // R3 bus-off entry combined with a good receive in the same cycle
    for (int i = 0; i < 15; i++) pulse(1, 0, 0, 0);
    check("R3 passive at 254", int'(state), 1);
    pulse(1, 0, 0, 1);
    check("R3 tec 262", int'(tec), 262);
    check("R2 rec dec same cycle", int'(rec), 254);
    check("R3 busoff", int'(state), 2);
    check("R5 online busoff", int'(online), 0);
    check("R5 flag busoff", int'(flag_dom), 0);

    // R6 events ignored in bus-off
    pulse(0, 1, 1, 0);
    pulse(1, 0, 0, 1);
    check("R6 tec held", int'(tec), 262);
    check("R6 rec held", int'(rec), 254);

    // R8 dominant restarts run, completed runs kept
    sample(1, 5);
    sample(0, 1);
    sample(1, 60 * 11);
    sample(1, 4);
    sample(0, 1);
    sample(1, 67 * 11);
    sample(1, 10);
    check("R8 still busoff", int'(state), 2);
    check("R6 tec during recovery", int'(tec), 262);
    sample(1, 1);
    // R7 recovery
    check("R7 state active", int'(state), 0);
    check("R7 tec cleared", int'(tec), 0);
    check("R7 rec cleared", int'(rec), 0);
    check("R7 warn low", int'(warn), 0);
    check("R7 online", int'(online), 1);
    pulse(1, 0, 1, 0);
    check("R1 tec after recovery", int'(tec), 8);
    check("R2 rec after recovery", int'(rec), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule